// File: doc/BRIEF.md
# Error Report Log Register

This block is the per-node record of error reports. Each node keeps one 16-bit word holding the latest reported error type and the reporting node's identifier, a saturating tally of how many reports arrived since the last clearing, and a sticky flag that records whether recovery logic judged any of those reports permanent. Every completed error report is applied through a load strobe. A special load marks the interchange command, which empties the tally and clears the flag.

Software can only read the word. A read strobe copies the word into a registered read port. The same cycle also latches a one-bit interpretation that tells whether more than one error is represented. The only way to change the word is through loads and the recovery mark, so software has no write path.

Top module: `erl_log`

## Requirements
- R1: After synchronous reset the log word, the read data and the multi-error flag are all zero.
- R2: The log word is packed with the permanent flag in bit 15, the count in bits 14:13, the error type in bits 12:9 and the node identifier in bits 8:0.
- R3: An ordinary load (`ld_i`=1, `ld_xchg_i`=0) replaces the type and node fields with the inputs on the next cycle, whatever they held before.
- R4: An ordinary load raises the count by one, and the count stays at 3 once it gets there.
- R5: An interchange load (`ld_i`=1, `ld_xchg_i`=1) writes the type and node fields, sets the count to 0 and clears the permanent flag. It does not increment the count.
- R6: `perm_mark_i` sets the permanent flag on the next cycle, and the flag stays set until an interchange load. A mark in the same cycle as any load also takes effect, so a mark given together with an interchange load leaves the flag at 1.
- R7: With `ld_i` and `perm_mark_i` low, the log word holds its value no matter how the type and node inputs change.
- R8: A read strobe copies the current log word, as it stood before any same-cycle update, to `rd_data_o` one cycle later. Without a strobe `rd_data_o` holds.
- R9: The multi-error flag is latched with the read. It is 1 when the count is 3, or when the count is 2 unless the permanent flag is set and the type differs from the unsafe-module code (14).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_i | input | 1 | Report load strobe |
| ld_xchg_i | input | 1 | Marks the load as the interchange command |
| ld_type_i | input | 4 | Error type of the report |
| ld_node_i | input | 9 | Node identifier of the report |
| perm_mark_i | input | 1 | Permanent mark from recovery logic |
| rd_en_i | input | 1 | Read strobe |
| log_o | output | 16 | Current log word |
| rd_data_o | output | 16 | Registered read data |
| rd_multi_o | output | 1 | Registered multi-error interpretation |

## Verification
Two pairs of functions can fall in the same cycle. A load can coincide with a permanent mark, and an interchange clear can coincide with a mark. The bench drives each pair in one cycle, both directed and at random. A behavioural model applies the clear before the mark and judges the flag and the count on the following cycle. A read in the same cycle as a load is also provoked, and it must return the word from before the load.

// File: rtl/erl_pkg.sv
package erl_pkg;
  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_ERR  = 2'd1,
    LD_XCHG = 2'd2
  } ld_kind_e;
endpackage

// File: rtl/erl_count.sv
module erl_count
  import erl_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  ld_kind_e         kind,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      case (kind)
        LD_XCHG: cnt_q <= '0;
        LD_ERR:  if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    (kind == LD_ERR && cnt_q != CMAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_count_saturate_R4: assert property (@(posedge clk) disable iff (rst)
    (kind == LD_ERR && cnt_q == CMAX) |=> cnt_q == CMAX);
  assert_count_cleared_R5: assert property (@(posedge clk) disable iff (rst)
    (kind == LD_XCHG) |=> cnt_q == '0);
  assert_count_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (kind == LD_IDLE) |=> $stable(cnt_q));
endmodule

// File: rtl/erl_fields.sv
module erl_fields
  import erl_pkg::*;
#(
  parameter int TYPE_W = 4,
  parameter int NODE_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  ld_kind_e          kind,
  input  logic [TYPE_W-1:0] type_i,
  input  logic [NODE_W-1:0] node_i,
  input  logic              mark_i,
  output logic [TYPE_W-1:0] type_q,
  output logic [NODE_W-1:0] node_q,
  output logic              perm_q
);
  logic perm_base;

  always_comb begin
    perm_base = (kind == LD_XCHG) ? 1'b0 : perm_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      type_q <= '0;
      node_q <= '0;
      perm_q <= 1'b0;
    end else begin
      if (kind != LD_IDLE) begin
        type_q <= type_i;
        node_q <= node_i;
      end
      perm_q <= perm_base | mark_i;
    end
  end

  assert_overwrite_R3: assert property (@(posedge clk) disable iff (rst)
    (kind != LD_IDLE) |=> (type_q == $past(type_i) && node_q == $past(node_i)));
  assert_mark_sets_R6: assert property (@(posedge clk) disable iff (rst)
    mark_i |=> perm_q);
  assert_perm_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (perm_q && kind != LD_XCHG) |=> perm_q);
  assert_xchg_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (kind == LD_XCHG && !mark_i) |=> !perm_q);
endmodule

// File: rtl/erl_log.sv
module erl_log
  import erl_pkg::*;
#(
  parameter int TYPE_W      = 4,
  parameter int NODE_W      = 9,
  parameter int CNT_W       = 2,
  parameter int UNSAFE_TYPE = 14
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            ld_i,
  input  logic                            ld_xchg_i,
  input  logic [TYPE_W-1:0]               ld_type_i,
  input  logic [NODE_W-1:0]               ld_node_i,
  input  logic                            perm_mark_i,
  input  logic                            rd_en_i,
  output logic [1+CNT_W+TYPE_W+NODE_W-1:0] log_o,
  output logic [1+CNT_W+TYPE_W+NODE_W-1:0] rd_data_o,
  output logic                            rd_multi_o
);
  localparam int LOG_W = 1 + CNT_W + TYPE_W + NODE_W;
  localparam logic [TYPE_W-1:0] UNSAFE_V = TYPE_W'(UNSAFE_TYPE);
  localparam logic [CNT_W-1:0]  CNT_TWO  = CNT_W'(2);

  ld_kind_e          kind;
  logic [CNT_W-1:0]  cnt_q;
  logic [TYPE_W-1:0] type_q;
  logic [NODE_W-1:0] node_q;
  logic              perm_q;
  logic              multi_now;

  always_comb begin
    if (!ld_i)          kind = LD_IDLE;
    else if (ld_xchg_i) kind = LD_XCHG;
    else                kind = LD_ERR;
  end

  erl_count #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst   (rst),
    .kind  (kind),
    .cnt_q (cnt_q)
  );

  erl_fields #(.TYPE_W(TYPE_W), .NODE_W(NODE_W)) u_fields (
    .clk    (clk),
    .rst    (rst),
    .kind   (kind),
    .type_i (ld_type_i),
    .node_i (ld_node_i),
    .mark_i (perm_mark_i),
    .type_q (type_q),
    .node_q (node_q),
    .perm_q (perm_q)
  );

  always_comb begin
    log_o = {perm_q, cnt_q, type_q, node_q};
    if (cnt_q > CNT_TWO)       multi_now = 1'b1;
    else if (cnt_q == CNT_TWO) multi_now = !(perm_q && type_q != UNSAFE_V);
    else                       multi_now = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o  <= '0;
      rd_multi_o <= 1'b0;
    end else if (rd_en_i) begin
      rd_data_o  <= log_o;
      rd_multi_o <= multi_now;
    end
  end

  assert_read_capture_R8: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> rd_data_o == $past(log_o));
  assert_read_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rd_data_o) && $stable(rd_multi_o));
  assert_log_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!ld_i && !perm_mark_i) |=> $stable(log_o));
  assert_no_multi_low_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && cnt_q < CNT_TWO) |=> !rd_multi_o);
  initial assert (LOG_W >= 4) else $error("log width too small");
endmodule

// File: tb/erl_log_tb.sv
module erl_log_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_i = 0, ld_xchg_i = 0, perm_mark_i = 0, rd_en_i = 0;
  logic [3:0] ld_type_i = 0;
  logic [8:0] ld_node_i = 0;
  logic [15:0] log_o, rd_data_o;
  logic rd_multi_o;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_perm = 0, m_cnt = 0, m_type = 0, m_node = 0, m_rd = 0, m_multi = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  erl_log dut_i (
    .clk(clk), .rst(rst), .ld_i(ld_i), .ld_xchg_i(ld_xchg_i),
    .ld_type_i(ld_type_i), .ld_node_i(ld_node_i), .perm_mark_i(perm_mark_i),
    .rd_en_i(rd_en_i), .log_o(log_o), .rd_data_o(rd_data_o), .rd_multi_o(rd_multi_o)
  );

  function automatic int packw();
    return (m_perm << 15) | (m_cnt << 13) | (m_type << 9) | m_node;
  endfunction

  function automatic int multi_of();
    if (m_cnt == 3) return 1;
    if (m_cnt == 2) return (m_perm == 1 && m_type != 14) ? 0 : 1;
    return 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 log word", int'(log_o), packw());
    chk("R3 type", int'(log_o[12:9]), m_type);
    chk("R3 node", int'(log_o[8:0]), m_node);
    chk("R4 count", int'(log_o[14:13]), m_cnt);
    chk("R6 perm", int'(log_o[15]), m_perm);
    chk("R8 read data", int'(rd_data_o), m_rd);
    chk("R9 multi", int'(rd_multi_o), m_multi);
  endtask

  task automatic step(bit ld, bit x, int ty, int nd, bit mk, bit rd);
    ld_i = ld; ld_xchg_i = x; ld_type_i = ty[3:0]; ld_node_i = nd[8:0];
    perm_mark_i = mk; rd_en_i = rd;
    if (rd) begin m_rd = packw(); m_multi = multi_of(); end
    if (ld && x) begin m_type = ty & 15; m_node = nd & 511; m_cnt = 0; m_perm = 0; end
    else if (ld) begin m_type = ty & 15; m_node = nd & 511; if (m_cnt < 3) m_cnt++; end
    if (mk) m_perm = 1;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset log", int'(log_o), 0);
    chk("R1 reset read", int'(rd_data_o), 0);
    chk("R1 reset multi", int'(rd_multi_o), 0);
    // R3/R4: five loads, count saturates at 3, last fields win
    for (int i = 0; i < 5; i++) step(1, 0, i + 3, 100 + i, 0, 0);
    chk("R4 saturated", int'(log_o[14:13]), 3);
    chk("R3 last wins", int'(log_o[8:0]), 104);
    step(0, 0, 0, 0, 0, 1); // R9 count 3 -> multi
    chk("R9 count three", int'(rd_multi_o), 1);
    // R5: interchange clears
    step(1, 1, 9, 300, 0, 0);
    chk("R5 count zero", int'(log_o[14:13]), 0);
    chk("R5 fields", int'(log_o[12:0]), (9 << 9) | 300);
    // R6: load and mark together
    step(1, 0, 2, 7, 1, 0);
    chk("R6 load+mark", int'(log_o[15:13]), 3'b101);
    step(1, 0, 5, 8, 0, 1); // read before update
    chk("R8 pre-update read", int'(rd_data_o), (1 << 15) | (1 << 13) | (2 << 9) | 7);
    step(0, 0, 0, 0, 0, 1); // count 2, perm, type 5 -> single
    chk("R9 perm single", int'(rd_multi_o), 0);
    // R7: idle with wiggling inputs
    for (int i = 0; i < 4; i++) step(0, i[0], 15 - i, 400 + i, 0, 0);
    chk("R7 held", int'(log_o), (1 << 15) | (2 << 13) | (5 << 9) | 8);
    // R6: mark with interchange leaves perm set
    step(1, 1, 1, 1, 1, 0);
    chk("R6 xchg+mark", int'(log_o[15:13]), 3'b100);
    step(1, 1, 1, 1, 0, 0);
    chk("R5 perm cleared", int'(log_o[15]), 0);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      step(r < 45, r < 5, $urandom_range(0, 15), $urandom_range(0, 511),
           $urandom_range(0, 99) < 8, $urandom_range(0, 99) < 40);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule